// File: doc/BRIEF.md
# Clearable Word Memory with Two-Cycle Array Wipe

A clocked model of a small static memory that holds 1024 words of 4 bits, stored as 64 rows of 64 bits. It has a separate write-data port and read-data port and four active-low strobes: select, write, read-enable and wipe. Every strobe is sampled on the rising clock edge, and each clock cycle counts as one memory cycle. A selected cycle with the write strobe low stores the input word. A selected cycle with read-enable low and write high returns the addressed word one clock later, together with a per-bit drive-enable that stands in for a three-state output.

The wipe strobe clears the whole array in two memory cycles. The lower half of the address space is cleared on the edge that samples the request. The upper half is cleared on the next edge, and that second step runs whatever the strobes do then. The wipe only acts on a selected device, so one shared wipe line can clear just the memories whose select is low. A `busy` output marks the second wipe cycle. A read sampled in that cycle returns zero.

Top module: `sram_clr`

## Requirements
- R1: When `rst_n` is low, `busy` is 0 and `dout_en` is 0 on the following edge. `rst_n` does not clear the array.
- R2: A write is accepted on an edge that samples `cs_n`=0, `we_n`=0, `clr_n`=1 and `busy`=0. It stores `din` at word `addr`, and a later read of that word returns it.
- R3: A read is sampled on an edge with `cs_n`=0, `oe_n`=0, `we_n`=1 and `clr_n`=1. After that edge, `dout` holds the addressed word and `dout_en` is 4'hF, until the next edge.
- R4: On the edge after any sampled cycle with `cs_n`=1, `oe_n`=1, `we_n`=0 or `clr_n`=0, `dout_en` is 4'h0 and `dout` is 4'h0.
- R5: An edge that samples `cs_n`=0 and `clr_n`=0 while `busy`=0 starts a wipe. It clears every word with `addr[9]`=0 and sets `busy` for exactly one cycle.
- R6: The edge that ends the busy cycle clears every word with `addr[9]`=1, even if `clr_n` is high or `cs_n` is high in that cycle. `busy` is then 0.
- R7: While `cs_n`=1, `clr_n`=0 changes no stored word and does not set `busy`.
- R8: When `clr_n`=0 and `we_n`=0 are sampled together in a selected cycle, the wipe wins and the write is discarded, so the addressed word reads 0.
- R9: A read sampled in the busy cycle returns 4'h0 with `dout_en`=4'hF for any address. A write sampled in the busy cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one memory cycle |
| rst_n | input | 1 | Active-low control reset (sequencer and output stage only) |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read enable |
| clr_n | input | 1 | Active-low array wipe request |
| addr | input | 10 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data, 0 when not driven |
| dout_en | output | 4 | Per-bit drive enable, 1 = driven, 0 = high impedance |
| busy | output | 1 | High during the second wipe cycle |

## Verification
A wrong wipe phase or a stuck sequencer shows at the ports within one cycle. `busy` stays high for a second cycle or never rises, and words of one address half survive a wipe, which the first read sweep afterwards exposes. A wrong write gate shows on the next read of the affected word: a write during the busy cycle, a write that beats the wipe, or a deselected wipe that destroys data. An output-stage fault shows on the edge after the offending sampled cycle, as a nonzero `dout_en` or stale data.

// File: rtl/sram_clr_pkg.sv
package sram_clr_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_UPPER = 1'b1
  } clr_phase_t;

  // Row index of a word: the bits above the column field.
  function automatic int unsigned row_index(input int unsigned a, input int unsigned col_w);
    return a >> col_w;
  endfunction

  // Column (word slot) inside a row.
  function automatic int unsigned col_index(input int unsigned a, input int unsigned col_w);
    return a & ((32'd1 << col_w) - 32'd1);
  endfunction

  // Bit offset of a word slot inside a row.
  function automatic int unsigned slot_lsb(input int unsigned col, input int unsigned data_w);
    return col * data_w;
  endfunction

endpackage

// File: rtl/sram_clr_ctrl.sv
module sram_clr_ctrl (
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic clr_n,
  input  logic busy,
  output logic clr_start,
  output logic wr_go,
  output logic rd_go
);
  logic sel;

  assign sel       = !cs_n;
  // The wipe outranks a write in the same cycle.
  assign clr_start = sel && !clr_n && !busy;
  assign wr_go     = sel && !we_n && clr_n && !busy;
  assign rd_go     = sel && !oe_n && we_n && clr_n;
endmodule

// File: rtl/sram_clr_seq.sv
module sram_clr_seq
  import sram_clr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_start,
  output logic clr_lo,
  output logic clr_hi,
  output logic busy
);
  clr_phase_t phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= PH_IDLE;
    else if (clr_start) phase_q <= PH_UPPER;
    else                phase_q <= PH_IDLE;
  end

  assign clr_lo = clr_start;
  assign clr_hi = (phase_q == PH_UPPER);
  assign busy   = clr_hi;

  // R5: a started wipe makes the device busy for the following cycle
  p_wipe_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start |=> busy);
  // R6: the busy phase lasts exactly one cycle
  p_busy_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/sram_clr_array.sv
module sram_clr_array
  import sram_clr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_lo,
  input  logic              clr_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word
);
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int HALF     = ROWS / 2;
  localparam int ROW_BITS = DATA_W << COL_W;

  logic [ROW_BITS-1:0] rows_q [ROWS];
  logic [ROW_W-1:0]    row_sel;
  int unsigned         lsb;

  assign row_sel = ROW_W'(row_index(32'(addr), COL_W));
  assign lsb     = slot_lsb(col_index(32'(addr), COL_W), DATA_W);
  assign rd_word = rows_q[row_sel][lsb +: DATA_W];

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if ((clr_lo && r < HALF) || (clr_hi && r >= HALF))
        rows_q[r] <= '0;
    end
    if (wr_en)
      rows_q[row_sel][lsb +: DATA_W] <= wr_data;
  end

  // R8 / R9: a write never coincides with either wipe step
  p_write_excl_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, clr_lo, clr_hi}));
endmodule

// File: rtl/sram_clr_rdport.sv
module sram_clr_rdport #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              busy,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_en
);
  logic              en_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      en_q   <= rd_go;
      data_q <= busy ? '0 : word;
    end
  end

  assign dout    = en_q ? data_q : '0;
  assign dout_en = {DATA_W{en_q}};

  // R4: no read sampled means no drive on the next cycle
  p_idle_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> (dout_en == '0));
endmodule

// File: rtl/sram_clr.sv
module sram_clr #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_en,
  output logic              busy
);
  logic clr_start, wr_go, rd_go, clr_lo, clr_hi;
  logic [DATA_W-1:0] rd_word;

  sram_clr_ctrl u_ctrl (
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n), .busy(busy),
    .clr_start(clr_start), .wr_go(wr_go), .rd_go(rd_go)
  );

  sram_clr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr_start(clr_start),
    .clr_lo(clr_lo), .clr_hi(clr_hi), .busy(busy)
  );

  sram_clr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .addr(addr), .wr_data(din), .rd_word(rd_word)
  );

  sram_clr_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .busy(busy), .word(rd_word),
    .dout(dout), .dout_en(dout_en)
  );

  // R4: a deselected cycle leaves the outputs undriven afterwards
  p_desel_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (dout_en == '0 && dout == '0));
  // R7: a wipe request on a deselected device does not start a wipe
  p_desel_no_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !busy) |=> !busy);
  // R9: a read in the busy cycle is driven and returns zero
  p_busy_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_n && !oe_n && we_n && clr_n) |=> (dout == '0 && dout_en == '1));
  // R1: control reset leaves the device idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && dout_en == '0));
endmodule

// File: tb/sram_clr_tb.sv
module sram_clr_tb;
  logic clk = 1'b0;
  logic rst_n, cs_n, we_n, oe_n, clr_n;
  logic [9:0] addr;
  logic [3:0] din, dout, dout_en;
  logic busy;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] model [1024];

  always #5 clk = ~clk;

  sram_clr u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, then return at the next falling edge.
  task automatic step(input logic c, input logic w, input logic o, input logic r,
                      input logic [9:0] a, input logic [3:0] d);
    cs_n = c; we_n = w; oe_n = o; clr_n = r; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] d);
    step(0, 0, 1, 1, a, d);
    model[a] = d;
  endtask

  task automatic rd_check(input string req, input logic [9:0] a);
    step(0, 1, 0, 1, a, 4'h0);
    chk(req, {dout_en, dout}, {4'hF, model[a]});
  endtask

  function automatic logic [3:0] pat(input int a, input int s);
    return 4'((a * 7 + s) ^ (a >> 5));
  endfunction

  task automatic fill(input int s);
    for (int a = 0; a < 1024; a++) wr(10'(a), pat(a, s));
  endtask

  task automatic sweep(input string req);
    int bad = 0;
    for (int a = 0; a < 1024; a++) begin
      step(0, 1, 0, 1, 10'(a), 4'h0);
      if (dout !== model[a] || dout_en !== 4'hF) bad++;
    end
    chk(req, 8'(bad), 8'd0);
  endtask

  task automatic t_reset;
    rst_n = 0;
    step(1, 1, 1, 1, 10'd0, 4'h0);
    step(1, 1, 1, 1, 10'd0, 4'h0);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 dout_en", {4'd0, dout_en}, 8'd0);
    rst_n = 1;
    step(1, 1, 1, 1, 10'd0, 4'h0);
  endtask

  task automatic t_write_read;
    fill(3);
    rd_check("R2 R3 word0", 10'd0);
    rd_check("R2 R3 word511", 10'd511);
    rd_check("R2 R3 word512", 10'd512);
    rd_check("R2 R3 word1023", 10'd1023);
    wr(10'd300, 4'hA);
    rd_check("R2 overwrite", 10'd300);
    sweep("R2 R3 full sweep");
  endtask

  task automatic t_output_off;
    step(0, 1, 1, 1, 10'd5, 4'h0);
    chk("R4 oe_n high", {dout_en, dout}, 8'h00);
    step(1, 1, 0, 1, 10'd5, 4'h0);
    chk("R4 cs_n high", {dout_en, dout}, 8'h00);
    wr(10'd5, 4'h6);
    chk("R4 we_n low", {dout_en, dout}, 8'h00);
    step(1, 1, 0, 0, 10'd5, 4'h0);
    chk("R4 clr_n low deselected", {dout_en, dout}, 8'h00);
    rd_check("R4 read after", 10'd5);
  endtask

  task automatic t_desel_wipe;
    step(1, 1, 1, 0, 10'd0, 4'h0);
    chk("R7 busy stays low", {7'd0, busy}, 8'd0);
    step(1, 0, 1, 0, 10'd700, 4'h0);
    sweep("R7 contents kept");
  endtask

  task automatic t_wipe;
    fill(9);
    // Start a wipe, then release it and deselect during the busy cycle.
    step(0, 1, 1, 0, 10'd0, 4'h0);
    chk("R5 busy set", {7'd0, busy}, 8'd1);
    chk("R4 clr_n low", {4'd0, dout_en}, 8'd0);
    step(1, 1, 1, 1, 10'd0, 4'h0);
    chk("R6 busy cleared", {7'd0, busy}, 8'd0);
    for (int a = 0; a < 1024; a++) model[a] = 4'h0;
    sweep("R5 R6 all zero");
  endtask

  task automatic t_busy_read_write;
    fill(5);
    step(0, 1, 1, 0, 10'd0, 4'h0);
    step(0, 1, 0, 1, 10'd900, 4'h0);
    chk("R9 busy read zero", {dout_en, dout}, 8'hF0);
    for (int a = 0; a < 1024; a++) model[a] = 4'h0;
    fill(6);
    step(0, 1, 1, 0, 10'd0, 4'h0);
    step(0, 0, 1, 1, 10'd20, 4'hD);
    for (int a = 0; a < 1024; a++) model[a] = 4'h0;
    rd_check("R9 busy write dropped", 10'd20);
  endtask

  task automatic t_priority;
    fill(2);
    step(0, 0, 1, 0, 10'd33, 4'hE);
    step(1, 1, 1, 1, 10'd0, 4'h0);
    for (int a = 0; a < 1024; a++) model[a] = 4'h0;
    rd_check("R8 write loses to wipe", 10'd33);
    rd_check("R8 upper cleared", 10'd1000);
  endtask

  initial begin
    rst_n = 0; cs_n = 1; we_n = 1; oe_n = 1; clr_n = 1; addr = '0; din = '0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_output_off();
    t_desel_wipe();
    t_wipe();
    t_busy_read_write();
    t_priority();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule